// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block brings up a target FPGA through its one-bit serial configuration port. A host pulses `start_i` with the bitstream length in bytes on `byte_count_i`. It then supplies the bitstream as a valid/ready byte stream. The loader first pulls the target's program line low and waits for the target to answer by pulling its init line low. It then releases program and waits for init to go high again. Only then does it begin shifting bytes out, most significant bit first, on a data pin sampled by the target at each rising edge of the configuration clock.

Before every byte, and once more after the final byte, the loader looks for the target's in-band CRC error indication: init active (low) while done is still low. After the last byte it keeps pulsing the configuration clock with the data pin held high until done rises. The outcome is a one-cycle `ok_o` pulse, or a one-cycle `abort_o` pulse together with a held cause code. Timing comes from two parameters. `STEP_DIV` sets how many system clocks each clock-low, data and clock-high phase lasts. `TIMEOUT_CYC` bounds each of the three waits on the target.

States: `S_IDLE` goes to `S_PROG` on start. `S_PROG` goes to `S_INIT_WAIT` when init is seen low, or to `S_FAIL` on timeout. `S_INIT_WAIT` goes to `S_CHECK` when init is seen high, or to `S_FAIL` on timeout. `S_CHECK` goes to `S_FAIL` on a CRC error, to `S_FLUSH_LO` when no bytes are left, and otherwise to `S_FETCH`. `S_FETCH` goes to `S_CLK_LO` when a byte is taken. The bit loop runs `S_CLK_LO` to `S_DATA` to `S_CLK_HI`, and `S_CLK_HI` returns to `S_CLK_LO` or, after the eighth bit, to `S_CHECK`. The flush loop runs `S_FLUSH_LO` to `S_FLUSH_HI` and back, and leaves for `S_PASS` on done or for `S_FAIL` on timeout. `S_PASS` and `S_FAIL` each last one cycle and return to `S_IDLE`.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, prog_n_o=1, cclk_o=0, din_o=0, s_ready_o=0, busy_o=0, ok_o=0, abort_o=0 and fail_cause_o=0.
- R2: A start in idle drives prog_n_o low and holds it low until init_n_i is seen low. If that takes TIMEOUT_CYC cycles, the load aborts with cause 1. No configuration clock edge occurs while program is low.
- R3: Once program is released, the loader waits for init_n_i to return high before sending data. If that takes TIMEOUT_CYC cycles, the load aborts with cause 2.
- R4: Before each byte, and after the last byte, init_n_i low together with done_i low aborts the load with cause 3. No further byte is accepted after that.
- R5: Each byte produces 8 rising edges of cclk_o carrying its bits most significant first. din_o is stable in the cycle cclk_o rises.
- R6: Within a byte, the clock-low, data and clock-high phases each last STEP_DIV system clocks, so rising edges are 3*STEP_DIV cycles apart.
- R7: s_ready_o is high only while waiting for a byte. The next byte is taken only after the eighth rising edge of the previous one. Exactly byte_count_i bytes are accepted on a successful load.
- R8: After the last byte, din_o stays high while cclk_o toggles every STEP_DIV cycles until done_i is seen high. ok_o then pulses for one cycle with cause 0.
- R9: If done_i is not seen high within TIMEOUT_CYC cycles of flush, the load aborts with cause 4.
- R10: abort_o is a one-cycle pulse on any failure. fail_cause_o (0 none, 1 init-start timeout, 2 init-clear timeout, 3 CRC error, 4 done timeout) holds until the next accepted start clears it.
- R11: start_i is ignored while busy_o is high.
- R12: With byte_count_i=0 the loader goes straight from the init handshake to the flush phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (taken in idle only) |
| byte_count_i | input | CNT_W | Number of bitstream bytes, sampled at start |
| s_data_i | input | DATA_W | Bitstream byte |
| s_valid_i | input | 1 | Byte on s_data_i is valid |
| s_ready_o | output | 1 | Loader takes the byte this cycle if valid |
| init_n_i | input | 1 | Target init line, active low |
| done_i | input | 1 | Target done line, high when configured |
| prog_n_o | output | 1 | Target program line, active low |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | One-cycle pulse on successful load |
| abort_o | output | 1 | One-cycle pulse on any failure |
| fail_cause_o | output | 3 | Cause of the last failure, 0 when none |

## Verification
The assertions assume the target behaves like a real device. Init falls only in response to program and rises again only after program is released. Done rises only once all data has been clocked in. start_i is a single-cycle pulse. The bench's target model follows exactly these rules: it answers program on the falling edge of the system clock, raises done after a chosen number of flush edges, and injects a CRC error only after a chosen number of complete bytes. Byte data is held stable from the cycle ready is seen until the handshake edge has passed.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PROG,
        S_INIT_WAIT,
        S_CHECK,
        S_FETCH,
        S_CLK_LO,
        S_DATA,
        S_CLK_HI,
        S_FLUSH_LO,
        S_FLUSH_HI,
        S_PASS,
        S_FAIL
    } ld_state_t;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_INIT_START = 3'd1,
        CAUSE_INIT_CLEAR = 3'd2,
        CAUSE_CRC        = 3'd3,
        CAUSE_DONE       = 3'd4
    } fail_cause_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= RST_VAL;
                else        r_q <= d;
            end
            assign q = r_q;
        end else begin : g_chain
            logic [STAGES-1:0] r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= {STAGES{RST_VAL}};
                else        r_q <= {r_q[STAGES-2:0], d};
            end
            assign q = r_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cfg_step_timer.sv
module cfg_step_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (!tick)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    assign expired = (cnt_q >= W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 16,
    parameter int STEP_DIV    = 4,
    parameter int TIMEOUT_CYC = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    input  logic              init_n_i,
    input  logic              done_i,
    output logic              prog_n_o,
    output logic              cclk_o,
    output logic              din_o,
    output logic              busy_o,
    output logic              ok_o,
    output logic              abort_o,
    output logic [2:0]        fail_cause_o
);
    localparam int                BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);

    ld_state_t         state_q, state_d;
    fail_cause_t       cause_d;
    logic [2:0]        cause_q;
    logic [DATA_W-1:0] sh_q;
    logic [BIT_W-1:0]  bit_q;
    logic [CNT_W-1:0]  left_q;
    logic              init_s, done_s;
    logic              tick, tmo, tmo_clr;
    logic              fl_q, fl_d;
    logic              prog_n_q, cclk_q, din_q;

    // Target lines cross into the system clock domain
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
        .clk(clk), .rst_n(rst_n), .d(init_n_i), .q(init_s)
    );
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst_n(rst_n), .d(done_i), .q(done_s)
    );

    // Phase timer restarts on every state change
    cfg_step_timer #(.DIV(STEP_DIV)) u_step (
        .clk(clk), .rst_n(rst_n), .restart(state_q != state_d), .tick(tick)
    );

    // One wait timer serves all three waits; it spans the whole flush loop
    assign fl_q    = (state_q == S_FLUSH_LO) || (state_q == S_FLUSH_HI);
    assign fl_d    = (state_d == S_FLUSH_LO) || (state_d == S_FLUSH_HI);
    assign tmo_clr = (state_q != state_d) && !(fl_q && fl_d);

    cfg_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .expired(tmo)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        cause_d = CAUSE_NONE;
        unique case (state_q)
            S_IDLE:      if (start_i) state_d = S_PROG;
            S_PROG: begin
                if (!init_s)  state_d = S_INIT_WAIT;
                else if (tmo) begin state_d = S_FAIL; cause_d = CAUSE_INIT_START; end
            end
            S_INIT_WAIT: begin
                if (init_s)   state_d = S_CHECK;
                else if (tmo) begin state_d = S_FAIL; cause_d = CAUSE_INIT_CLEAR; end
            end
            S_CHECK: begin
                if (!init_s && !done_s) begin state_d = S_FAIL; cause_d = CAUSE_CRC; end
                else if (left_q == '0)  state_d = S_FLUSH_LO;
                else                    state_d = S_FETCH;
            end
            S_FETCH:     if (s_valid_i) state_d = S_CLK_LO;
            S_CLK_LO:    if (tick) state_d = S_DATA;
            S_DATA:      if (tick) state_d = S_CLK_HI;
            S_CLK_HI:    if (tick) state_d = (bit_q == LAST_BIT) ? S_CHECK : S_CLK_LO;
            S_FLUSH_LO: begin
                if (done_s)    state_d = S_PASS;
                else if (tmo)  begin state_d = S_FAIL; cause_d = CAUSE_DONE; end
                else if (tick) state_d = S_FLUSH_HI;
            end
            S_FLUSH_HI: begin
                if (done_s)    state_d = S_PASS;
                else if (tmo)  begin state_d = S_FAIL; cause_d = CAUSE_DONE; end
                else if (tick) state_d = S_FLUSH_LO;
            end
            S_PASS:      state_d = S_IDLE;
            S_FAIL:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Byte, bit and cause bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            bit_q   <= '0;
            left_q  <= '0;
            cause_q <= '0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                left_q  <= byte_count_i;
                cause_q <= '0;
            end
            if (state_q == S_FETCH && s_valid_i) begin
                sh_q   <= s_data_i;
                left_q <= left_q - 1'b1;
                bit_q  <= '0;
            end
            if (state_q == S_CLK_HI && tick) begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end
            if (cause_d != CAUSE_NONE) cause_q <= cause_d;
        end
    end

    // Pin outputs, registered from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_n_q <= 1'b1;
            cclk_q   <= 1'b0;
            din_q    <= 1'b0;
        end else begin
            prog_n_q <= (state_d != S_PROG);
            case (state_d)
                S_IDLE:     begin cclk_q <= 1'b0; din_q <= 1'b0; end
                S_CLK_LO:   cclk_q <= 1'b0;
                S_DATA:     din_q  <= sh_q[DATA_W-1];
                S_CLK_HI:   cclk_q <= 1'b1;
                S_FLUSH_LO: begin cclk_q <= 1'b0; din_q <= 1'b1; end
                S_FLUSH_HI: begin cclk_q <= 1'b1; din_q <= 1'b1; end
                default:    ;
            endcase
        end
    end

    always_comb begin
        prog_n_o     = prog_n_q;
        cclk_o       = cclk_q;
        din_o        = din_q;
        s_ready_o    = (state_q == S_FETCH);
        busy_o       = (state_q != S_IDLE);
        ok_o         = (state_q == S_PASS);
        abort_o      = (state_q == S_FAIL);
        fail_cause_o = cause_q;
    end

    // Checks
    p_prog_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> busy_o);
    p_no_edge_in_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> !cclk_o);
    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(din_o));
    p_one_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready_o && s_valid_i) |=> !s_ready_o);
    p_flush_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH_HI) |-> din_o);
    p_ok_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |=> (!ok_o && !busy_o));
    p_ok_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (fail_cause_o == 3'd0));
    p_abort_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (!abort_o && !busy_o));
    p_abort_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (fail_cause_o != 3'd0));
endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
    localparam int DIV = 4;
    localparam int TMO = 300;
    localparam int CW  = 8;

    localparam logic [7:0] VEC [8] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C, 8'h7E, 8'hC3};

    typedef struct packed {
        logic [7:0] nb;
        logic       st_ok;
        logic       clr_ok;
        logic [7:0] crc_at;
        logic [7:0] done_after;
        logic [2:0] cause;
        logic [7:0] acc;
    } scen_t;

    // nb, start ok, clear ok, crc after byte (FF none), done after flush edges (FF never), cause, accepted
    localparam scen_t SCN [8] = '{
        '{8'd8, 1'b1, 1'b1, 8'hFF, 8'd3,  3'd0, 8'd8},
        '{8'd3, 1'b1, 1'b1, 8'hFF, 8'd0,  3'd0, 8'd3},
        '{8'd4, 1'b0, 1'b1, 8'hFF, 8'd0,  3'd1, 8'd0},
        '{8'd4, 1'b1, 1'b0, 8'hFF, 8'd0,  3'd2, 8'd0},
        '{8'd6, 1'b1, 1'b1, 8'd2,  8'hFF, 3'd3, 8'd2},
        '{8'd5, 1'b1, 1'b1, 8'd5,  8'hFF, 3'd3, 8'd5},
        '{8'd2, 1'b1, 1'b1, 8'hFF, 8'hFF, 3'd4, 8'd2},
        '{8'd0, 1'b1, 1'b1, 8'hFF, 8'd2,  3'd0, 8'd0}
    };

    logic          clk, rst_n, start, s_valid, s_ready, init_n, done;
    logic [CW-1:0] byte_count;
    logic [7:0]    s_data;
    logic          prog_n, cclk, din, busy, ok, abort_p;
    logic [2:0]    cause;

    int n_checks = 0, n_err = 0;
    int cyc = 0, cap_bits, flush_edges, flush_bad, per_bad, gap_bad, acc_cnt, edges_since;
    int last_rise, prog_low, ok_seen, abort_seen, rel_dly;
    int m_nb, m_crc_at, m_done_after;
    bit m_st_ok, m_clr_ok, armed, released, hs_pend, prev_cclk, tgt_reset, mon_en;
    logic [7:0] cap_cur;
    logic [7:0] cap [8];

    assign s_data = VEC[acc_cnt % 8];

    cfg_serial_loader #(
        .DATA_W(8), .CNT_W(CW), .STEP_DIV(DIV), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_count_i(byte_count),
        .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready),
        .init_n_i(init_n), .done_i(done), .prog_n_o(prog_n), .cclk_o(cclk),
        .din_o(din), .busy_o(busy), .ok_o(ok), .abort_o(abort_p), .fail_cause_o(cause)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!good) begin
            n_err++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor and target model, active on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (tgt_reset) begin init_n = 1'b1; done = 1'b0; tgt_reset = 1'b0; end
            if (mon_en) begin
                if (hs_pend) begin acc_cnt++; hs_pend = 1'b0; end
                if (cclk && !prev_cclk) begin
                    if (cap_bits < 8 * m_nb) begin
                        if ((cap_bits % 8) != 0 && (cyc - last_rise) != 3 * DIV) per_bad++;
                        cap_cur = {cap_cur[6:0], din};
                        cap_bits++;
                        edges_since++;
                        if ((cap_bits % 8) == 0) cap[cap_bits / 8 - 1] = cap_cur;
                    end else begin
                        if (flush_edges > 0 && (cyc - last_rise) != 2 * DIV) per_bad++;
                        if (!din) flush_bad++;
                        flush_edges++;
                    end
                    last_rise = cyc;
                end
                prev_cclk = cclk;
                if (s_ready && s_valid) begin
                    if (acc_cnt > 0 ? (edges_since != 8) : (cap_bits != 0)) gap_bad++;
                    edges_since = 0;
                    hs_pend = 1'b1;
                end
                if (!prog_n) prog_low++;
                if (ok) ok_seen++;
                if (abort_p) abort_seen++;
                if (!prog_n && m_st_ok) begin
                    init_n = 1'b0;
                    armed  = 1'b1;
                end else if (prog_n && armed && !released && m_clr_ok) begin
                    if (rel_dly == 5) begin init_n = 1'b1; released = 1'b1; end
                    else rel_dly++;
                end
                if (released && m_crc_at >= 0 && cap_bits >= 8 * m_crc_at) init_n = 1'b0;
                if (released && m_done_after >= 0 && cap_bits >= 8 * m_nb && flush_edges >= m_done_after)
                    done = 1'b1;
            end
        end
    end

    task automatic run(input int idx, input bit restart);
        scen_t s;
        string rq;
        s = SCN[idx];
        @(posedge clk);
        cap_bits = 0; flush_edges = 0; flush_bad = 0; per_bad = 0; gap_bad = 0;
        acc_cnt = 0; edges_since = 0; last_rise = 0; prog_low = 0; ok_seen = 0;
        abort_seen = 0; rel_dly = 0; armed = 1'b0; released = 1'b0; hs_pend = 1'b0;
        prev_cclk = cclk; cap_cur = '0;
        m_nb = s.nb; m_st_ok = s.st_ok; m_clr_ok = s.clr_ok;
        m_crc_at = (s.crc_at == 8'hFF) ? -1 : int'(s.crc_at);
        m_done_after = (s.done_after == 8'hFF) ? -1 : int'(s.done_after);
        tgt_reset = 1'b1; mon_en = 1'b1;
        repeat (3) @(negedge clk);
        byte_count = CW'(s.nb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cause == 3'd0, "R10", "cause cleared by start", cause, 0);
        chk(!prog_n, "R2", "program low after start", prog_n, 0);
        for (int w = 0; w < 20000 && ok_seen == 0 && abort_seen == 0; w++) begin
            @(negedge clk);
            start = restart && (w == 200);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        case (s.cause)
            3'd1: rq = "R2";
            3'd2: rq = "R3";
            3'd3: rq = "R4";
            3'd4: rq = "R9";
            default: rq = (s.nb == 0) ? "R12" : "R8";
        endcase
        chk(cause == s.cause, rq, $sformatf("cause, scenario %0d", idx), cause, s.cause);
        chk(ok_seen == ((s.cause == 0) ? 1 : 0), "R8", "ok pulses", ok_seen, (s.cause == 0) ? 1 : 0);
        chk(abort_seen == ((s.cause != 0) ? 1 : 0), "R10", "abort pulses", abort_seen, (s.cause != 0) ? 1 : 0);
        chk(acc_cnt == int'(s.acc), restart ? "R11" : "R7", "bytes accepted", acc_cnt, s.acc);
        chk(gap_bad == 0, "R7", "byte taken before 8th edge", gap_bad, 0);
        chk(per_bad == 0, "R6", "edge spacing violations", per_bad, 0);
        chk(flush_bad == 0, "R8", "flush edges with data low", flush_bad, 0);
        chk(!busy, "R10", "idle after result", busy, 0);
        for (int j = 0; j < int'(s.acc) && j < 8; j++)
            chk(cap[j] == VEC[j], "R5", $sformatf("serial byte %0d", j), cap[j], VEC[j]);
        if (s.cause == 0)
            chk(flush_edges >= int'(s.done_after), (s.nb == 0) ? "R12" : "R8", "flush edges", flush_edges, s.done_after);
        if (s.cause == 1)
            chk(prog_low >= TMO - 2 && prog_low <= TMO + 2, "R2", "program low cycles", prog_low, TMO);
        if (s.cause != 0) begin
            repeat (5) @(negedge clk);
            chk(cause == s.cause, "R10", "cause held after abort", cause, s.cause);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog (all requirements): cycles=%0d expected < %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; s_valid = 1'b1; byte_count = '0;
        init_n = 1'b1; done = 1'b0; mon_en = 1'b0; tgt_reset = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prog_n == 1'b1, "R1", "prog_n after reset", prog_n, 1);
        chk(cclk == 1'b0, "R1", "cclk after reset", cclk, 0);
        chk(din == 1'b0, "R1", "din after reset", din, 0);
        chk(s_ready == 1'b0, "R1", "ready after reset", s_ready, 0);
        chk(busy == 1'b0 && ok == 1'b0 && abort_p == 1'b0, "R1", "busy/ok/abort after reset",
            {busy, ok, abort_p}, 0);
        chk(cause == 3'd0, "R1", "cause after reset", cause, 0);

        for (int i = 0; i < 8; i++) run(i, 1'b0);

        // R11: a second start in the middle of a load must not restart it
        run(0, 1'b1);
        // A clean load right after a failure
        run(6, 1'b0);
        run(1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule